// File: doc/BRIEF.md
# Interrupt ID Encoder with Clear

This block gathers six peripheral interrupt requests into pending flags and shows the host a single 3-bit interrupt code on output pins. A source only becomes pending while its enable bit is set, and only when its request line goes from low to high. When several sources are pending at once, the smallest code is shown; after the host clears it, the next pending code appears.

The host writes all six enables in one strobe and clears pending flags with a one-byte clear command. Bit 7 of that byte clears everything. Otherwise, bits 2:0 name one code to clear. The code output is registered, so it always reflects the pending flags one clock earlier.

Top module: `intr_id_enc`

## Requirements
- R1: Source index i (req_i[i], en_val_i[i]) maps to interrupt code i+1: GPIO bank A = 1, GPIO bank B = 2, ADC = 3, SPI1 = 4, SPI2 = 5, I2C = 6. Code 0 means nothing is pending. irq_id_o[0] is the code's least significant bit, and the output never exceeds 6.
- R2: A flag becomes pending on a clock edge where its enable is set and req_i is high after being low at the previous edge. A request held high does not set the flag again. A pending flag stays set after its request line drops.
- R3: A pulse on en_wr_i loads all six enables from en_val_i. Reset clears the enables, the pending flags and the code output to zero.
- R4: When several flags are pending, the lowest pending code is shown.
- R5: A clear (clr_vld_i high) whose byte has bit 7 set clears every pending flag, whatever the low bits hold.
- R6: A clear with bit 7 low clears only the flag whose code equals byte bits 2:0, for values 1 to 6. Bits 6:3 are ignored. Field values 0 and 7 clear nothing.
- R7: If a new request edge and a clear (master or selective) hit the same source on the same clock edge, the flag ends up set.
- R8: A change of the pending flags at clock edge k shows on irq_id_o after edge k+1.
- R9: Clearing an enable keeps an already pending flag. Request edges seen while the enable is clear are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Per-source request levels (bit i is source i) |
| en_wr_i | input | 1 | Strobe that loads the enable register |
| en_val_i | input | 6 | Enable values to load |
| clr_vld_i | input | 1 | Clear command strobe |
| clr_byte_i | input | 8 | Clear byte: bit 7 clears everything, bits 2:0 give a code |
| irq_id_o | output | 3 | Code of the lowest pending source, 0 if none |

## Verification
A flag stuck set or lost shows as a wrong code two edges after the stimulus that should have changed it. A lost flag also shows later, as a missing code once the lower codes are cleared. Enable and edge-detect faults show the same way: a code appears for a disabled or held request, or fails to appear for a fresh edge. The stimulus includes clears with code values that match nothing, with noise in bits 6:3, and on the same cycle as a new request. A decode fault then appears as a code that should have stayed or gone.

// File: rtl/intr_id_pkg.sv
package intr_id_pkg;
   // Layout of the host clear byte
   localparam int unsigned CLR_BYTE_W  = 8;
   localparam int unsigned CLR_ALL_BIT = 7;   // set: clear every flag
   localparam int unsigned CLR_FIELD_W = 3;   // low bits: code to clear

   // Code width needed for n sources plus the "none" code
   function automatic int unsigned code_width(input int unsigned n);
      return (n + 1 <= 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/intr_pend_cell.sv
module intr_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic en_i,
   input  logic clr_i,
   output logic pend_o,
   output logic rise_o
);
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_i;
   end

   assign rise_o = en_i & req_i & ~req_q;

   // A fresh request outranks a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_o <= 1'b0;
      else if (rise_o) pend_o <= 1'b1;
      else if (clr_i)  pend_o <= 1'b0;
   end

   a_r7_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> pend_o);
   a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_o && !clr_i) |=> $stable(pend_o));
   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !pend_o) |=> !pend_o);
endmodule

// File: rtl/intr_clr_dec.sv
module intr_clr_dec
   import intr_id_pkg::*;
#(
   parameter int unsigned NUM_SRC = 6
) (
   input  logic                  clr_vld_i,
   input  logic [CLR_BYTE_W-1:0] clr_byte_i,
   output logic [NUM_SRC-1:0]    clr_mask_o
);
   logic                   master;
   logic [CLR_FIELD_W-1:0] field;
   logic                   unused_gap;

   assign master     = clr_byte_i[CLR_ALL_BIT];
   assign field      = clr_byte_i[CLR_FIELD_W-1:0];
   assign unused_gap = ^clr_byte_i[CLR_ALL_BIT-1:CLR_FIELD_W];

   initial begin : p_param_chk
      if (NUM_SRC < 1 || NUM_SRC >= (1 << CLR_FIELD_W))
         $error("intr_clr_dec: NUM_SRC must fit the clear field");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      assign clr_mask_o[i] = clr_vld_i &
                             (master | (field == CLR_FIELD_W'(i + 1)));
   end

   always_comb begin
      a_r6_single_clear: assert (!(clr_vld_i && !master) || $onehot0(clr_mask_o));
   end
endmodule

// File: rtl/intr_lowest_enc.sv
module intr_lowest_enc #(
   parameter int unsigned NUM_SRC     = 6,
   parameter int unsigned ID_W        = 3,
   parameter bit          ENC_ISOLATE = 1'b0
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [ID_W-1:0]    id_o
);
   initial begin : p_param_chk
      if ((NUM_SRC + 1) > (1 << ID_W))
         $error("intr_lowest_enc: ID_W too narrow for NUM_SRC");
   end

   if (ENC_ISOLATE) begin : g_isolate
      // Keep only the lowest set bit, then OR-encode it
      logic [NUM_SRC-1:0] iso;
      always_comb begin
         iso  = pend_i & (~pend_i + NUM_SRC'(1));
         id_o = '0;
         for (int i = 0; i < NUM_SRC; i++)
            if (iso[i]) id_o = id_o | ID_W'(i + 1);
      end
   end else begin : g_scan
      // Scan from the top so the lowest pending index is assigned last
      always_comb begin
         id_o = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--)
            if (pend_i[i]) id_o = ID_W'(i + 1);
      end
   end
endmodule

// File: rtl/intr_id_enc.sv
module intr_id_enc
   import intr_id_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 6,
   parameter bit          ENC_ISOLATE = 1'b0,
   localparam int unsigned ID_W       = code_width(NUM_SRC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    req_i,
   input  logic                  en_wr_i,
   input  logic [NUM_SRC-1:0]    en_val_i,
   input  logic                  clr_vld_i,
   input  logic [CLR_BYTE_W-1:0] clr_byte_i,
   output logic [ID_W-1:0]       irq_id_o
);
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] clr_mask;
   logic [NUM_SRC-1:0] pend_vec;
   logic [NUM_SRC-1:0] rise_vec;
   logic [ID_W-1:0]    next_id;
   logic [ID_W-1:0]    id_q;

   initial begin : p_param_chk
      if (CLR_ALL_BIT >= CLR_BYTE_W || CLR_FIELD_W > CLR_ALL_BIT)
         $error("intr_id_enc: clear byte layout is inconsistent");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_wr_i) en_q <= en_val_i;
   end

   intr_clr_dec #(.NUM_SRC(NUM_SRC)) u_clr (
      .clr_vld_i  (clr_vld_i),
      .clr_byte_i (clr_byte_i),
      .clr_mask_o (clr_mask)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      intr_pend_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_i  (req_i[i]),
         .en_i   (en_q[i]),
         .clr_i  (clr_mask[i]),
         .pend_o (pend_vec[i]),
         .rise_o (rise_vec[i])
      );
   end

   intr_lowest_enc #(
      .NUM_SRC     (NUM_SRC),
      .ID_W        (ID_W),
      .ENC_ISOLATE (ENC_ISOLATE)
   ) u_enc (
      .pend_i (pend_vec),
      .id_o   (next_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_q <= '0;
      else        id_q <= next_id;
   end

   assign irq_id_o = id_q;

   // Checker aids: bit named by the output code, and that bit plus all below
   logic [NUM_SRC-1:0] sel_bit;
   logic [NUM_SRC-1:0] mask_le;
   always_comb begin
      sel_bit = (irq_id_o == '0 || irq_id_o > ID_W'(NUM_SRC)) ? '0 :
                (NUM_SRC'(1) << (irq_id_o - ID_W'(1)));
      mask_le = (sel_bit == '0) ? '1 : (sel_bit | (sel_bit - NUM_SRC'(1)));
   end

   a_r1_id_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_id_o <= ID_W'(NUM_SRC));
   a_r4_lowest_shown: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_vec) & mask_le) == sel_bit));
   a_r8_id_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_id_o == '0) == ($past(pend_vec) == '0)));
   a_r5_master_all: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld_i && clr_byte_i[CLR_ALL_BIT] && rise_vec == '0) |=> pend_vec == '0);
   a_r6_null_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld_i && !clr_byte_i[CLR_ALL_BIT] &&
       (clr_byte_i[CLR_FIELD_W-1:0] == '0 || clr_byte_i[CLR_FIELD_W-1:0] == '1))
      |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec)));
   a_r3_en_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_q == '0 && pend_vec == '0));
endmodule

// File: tb/intr_id_enc_test.sv
module intr_id_enc_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 27;

   typedef struct packed {
      logic [5:0] req;
      logic       wr;
      logic [5:0] en;
      logic       cv;
      logic [7:0] cb;
      logic [2:0] exp;   // code expected before this row is driven (rows up to i-2)
      logic [3:0] tag;   // requirement number
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{6'h00, 1'b1, 6'h3F, 1'b0, 8'h00, 3'd0, 4'd3},  // 0  R3 enable all, nothing pending
      '{6'h04, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd2},  // 1  R2 ADC edge
      '{6'h04, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd8},  // 2  R8 not visible yet
      '{6'h24, 1'b0, 6'h00, 1'b0, 8'h00, 3'd3, 4'd8},  // 3  R8 ADC shows, I2C edge
      '{6'h25, 1'b0, 6'h00, 1'b0, 8'h00, 3'd3, 4'd4},  // 4  R4 GPIO A edge
      '{6'h25, 1'b0, 6'h00, 1'b0, 8'h00, 3'd3, 4'd4},  // 5  R4
      '{6'h25, 1'b0, 6'h00, 1'b1, 8'h01, 3'd1, 4'd4},  // 6  R4 lowest = 1; clear code 1
      '{6'h25, 1'b0, 6'h00, 1'b0, 8'h00, 3'd1, 4'd2},  // 7  R2 held request no relatch
      '{6'h25, 1'b0, 6'h00, 1'b1, 8'h7B, 3'd3, 4'd6},  // 8  R6 clear 3 with noise in 6:3
      '{6'h25, 1'b0, 6'h00, 1'b1, 8'h07, 3'd3, 4'd6},  // 9  R6 code 7 clears nothing
      '{6'h25, 1'b0, 6'h00, 1'b1, 8'h00, 3'd6, 4'd6},  // 10 R6 code 0 clears nothing
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd6, 4'd6},  // 11 R6 I2C still pending
      '{6'h02, 1'b0, 6'h00, 1'b1, 8'h02, 3'd6, 4'd2},  // 12 R7 edge and clear of 2 together
      '{6'h02, 1'b0, 6'h00, 1'b1, 8'h06, 3'd6, 4'd1},  // 13 R1 clear I2C
      '{6'h02, 1'b0, 6'h00, 1'b0, 8'h00, 3'd2, 4'd7},  // 14 R7 request won
      '{6'h02, 1'b1, 6'h00, 1'b0, 8'h00, 3'd2, 4'd9},  // 15 R9 disable everything
      '{6'h3F, 1'b0, 6'h00, 1'b0, 8'h00, 3'd2, 4'd9},  // 16 R9 edges while disabled
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd2, 4'd9},  // 17 R9 pending kept
      '{6'h00, 1'b0, 6'h00, 1'b1, 8'h80, 3'd2, 4'd9},  // 18 R9 master clear
      '{6'h00, 1'b1, 6'h10, 1'b0, 8'h00, 3'd2, 4'd9},  // 19 R9 enable SPI2 only
      '{6'h30, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd5},  // 20 R5 all cleared; SPI2+I2C edges
      '{6'h30, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd9},  // 21 R9
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd5, 4'd1},  // 22 R1 SPI2 = 5
      '{6'h00, 1'b0, 6'h00, 1'b1, 8'h80, 3'd5, 4'd5},  // 23 R5 master clear
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd5, 4'd5},  // 24 R5
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd5},  // 25 R5 masked I2C never pended
      '{6'h00, 1'b0, 6'h00, 1'b0, 8'h00, 3'd0, 4'd1}   // 26 R1 none = 0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] req = '0;
   logic       en_wr = 1'b0;
   logic [5:0] en_val = '0;
   logic       clr_vld = 1'b0;
   logic [7:0] clr_byte = '0;
   logic [2:0] irq_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   intr_id_enc uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .en_wr_i    (en_wr),
      .en_val_i   (en_val),
      .clr_vld_i  (clr_vld),
      .clr_byte_i (clr_byte),
      .irq_id_o   (irq_id)
   );

   task automatic check_id(input logic [2:0] exp, input int tag);
      n_cmp++;
      if (irq_id !== exp) begin
         n_bad++;
         $display("FAIL R%0d: irq_id actual %0d expected %0d at %0t", tag, irq_id, exp, $time);
      end
   endtask

   task automatic apply(input logic [5:0] r, input logic w, input logic [5:0] e,
                        input logic cv, input logic [7:0] cb);
      @(negedge clk);
      req = r; en_wr = w; en_val = e; clr_vld = cv; clr_byte = cb;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_id(3'd0, 3);                 // R3 output held at zero in reset
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         check_id(VEC[i].exp, int'(VEC[i].tag));
         req = VEC[i].req; en_wr = VEC[i].wr; en_val = VEC[i].en;
         clr_vld = VEC[i].cv; clr_byte = VEC[i].cb;
      end

      // R2 flag persists after request drops, then R3 reset clears it
      apply(6'h00, 1'b1, 6'h3F, 1'b0, 8'h00);
      apply(6'h01, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd1, 2);
      rst_n = 1'b0;
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd0, 3);
      rst_n = 1'b1;

      // R3 enables cleared by reset: edges on all sources are dropped
      apply(6'h3F, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h3F, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd0, 3);

      // R7 with master clear: new SPI1 edge survives a clear-all on the same edge
      apply(6'h00, 1'b1, 6'h0F, 1'b0, 8'h00);
      apply(6'h03, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h03, 1'b0, 6'h00, 1'b0, 8'h00);
      apply(6'h0B, 1'b0, 6'h00, 1'b1, 8'h80);
      apply(6'h0B, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd1, 4);                 // R4 codes 1 and 2 pending, 1 shown
      apply(6'h0B, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd4, 7);
      apply(6'h00, 1'b0, 6'h00, 1'b0, 8'h00);
      check_id(3'd4, 5);                 // R5 codes 1 and 2 gone

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule